// File: doc/BRIEF.md
# Two-Stage Pipelined Barrel Shifter

This block shifts a data word by a variable distance over two pipeline stages of an in-order core. In the first stage (execute) it takes an operand, a second operand whose low bits give the shift distance, a direction flag and an arithmetic/logical flag. The result appears in the following stage (memory). Only left shifts are built in hardware. A right shift mirrors the operand's bit order before the left-shift network and mirrors the result back after it.

The distance is applied in three layers, coarse and fine. The execute stage applies the lower distance bits in groups of two. For a 32-bit word these groups give steps of 0–3 and 0/4/8/12. The memory stage applies the top distance bit, which is a 0/16 step at 32 bits. The partial result, the top distance bit, the direction and the fill value are held in a register between the stages. That register loads only when the execute stage advances and the instruction is a shift, so a stalled or unrelated instruction leaves the memory-stage result as it was.

Top module: `bsh_pipe`

## Requirements
- R1: A left shift by n (n = shift distance) gives the operand moved n places towards the MSB, with the result truncated to the word width and zeros entering at bit 0.
- R2: A logical right shift by n (shift_left = 0, arith = 0) gives the operand moved n places towards the LSB, with zeros entering at the MSB.
- R3: An arithmetic right shift (shift_left = 0, arith = 1) fills the vacated upper positions with bit W-1 of the original operand.
- R4: The arith flag has no effect on a left shift: vacated bits are always zero.
- R5: The shift distance is bits [log2(W)-1:0] of the second operand; all higher bits of that operand are ignored.
- R6: A shift distance of zero returns the operand unchanged in every direction and mode.
- R7: When ex_run and ex_is_shift are both 1 at a rising clock edge, the result of that shift is on mem_result after that same edge.
- R8: At an edge where ex_run or ex_is_shift is 0, mem_result keeps its previous value whatever the other inputs are.
- R9: While rst_n is low, mem_result is zero, and it stays zero until a shift is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_run | input | 1 | Execute stage advances this cycle |
| ex_is_shift | input | 1 | Instruction in execute is a shift |
| ex_operand | input | W | Value to shift |
| ex_amount_src | input | W | Second operand; its low log2(W) bits give the distance |
| ex_shift_left | input | 1 | 1 = left shift, 0 = right shift |
| ex_arith | input | 1 | 1 = arithmetic (sign fill on right shifts) |
| mem_result | output | W | Shifted value in the memory stage |

## Verification
The bench builds two instances. The first is an 8-bit instance. It uses one two-bit execute group and a 0/4 memory step, which makes it small enough to sweep every operand, every distance and all four direction/mode combinations, with random upper bits on the second operand. The second is a 32-bit instance. It covers the full two-group execute split and the 0/16 memory layer, running every distance and mode against edge-pattern and random operands. Stall, non-shift and reset behaviour are driven directly on the 32-bit instance, and expected values come from a bit-by-bit reference shift.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

  // Control carried from execute into the memory stage
  typedef struct packed {
    logic amt_hi;  // top distance bit, applied in memory stage
    logic right;   // result must be mirrored back
    logic fill;    // value entering vacated positions
  } bsh_ctl_t;

endpackage

// File: rtl/bsh_rev.sv
module bsh_rev #(
  parameter int W = 32
) (
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] mirrored;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign mirrored[i] = d[W-1-i];
  end

  assign q = en ? mirrored : d;
endmodule

// File: rtl/bsh_layer.sv
module bsh_layer #(
  parameter int W     = 32,
  parameter int SEL_W = 2,
  parameter int STEP  = 1
) (
  input  logic [W-1:0]     d,
  input  logic [SEL_W-1:0] sel,
  input  logic             fill,
  output logic [W-1:0]     q
);
  localparam int SH_W = $clog2(W) + 1;

  logic [SH_W-1:0] sh;
  logic [W-1:0]    keep_mask;

  always_comb begin
    sh        = SH_W'(sel) * SH_W'(STEP);
    keep_mask = {W{1'b1}} << sh;
    q         = (d << sh) | (fill ? ~keep_mask : '0);
  end
endmodule

// File: rtl/bsh_ex_stage.sv
module bsh_ex_stage #(
  parameter int W    = 32,
  parameter int LO_W = 4
) (
  input  logic [W-1:0]    operand,
  input  logic [LO_W-1:0] amt_lo,
  input  logic            right,
  input  logic            fill,
  output logic [W-1:0]    mid
);
  localparam int NGRP = (LO_W + 1) / 2;

  logic [W-1:0] chain [NGRP+1];

  bsh_rev #(.W(W)) u_rev_in (
    .en (right),
    .d  (operand),
    .q  (chain[0])
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int BASE = 2 * g;
    localparam int GW   = (BASE + 2 <= LO_W) ? 2 : 1;
    bsh_layer #(.W(W), .SEL_W(GW), .STEP(1 << BASE)) u_layer (
      .d    (chain[g]),
      .sel  (amt_lo[BASE+GW-1:BASE]),
      .fill (fill),
      .q    (chain[g+1])
    );
  end

  assign mid = chain[NGRP];
endmodule

// File: rtl/bsh_pipe.sv
module bsh_pipe
  import bsh_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ex_run,
  input  logic         ex_is_shift,
  input  logic [W-1:0] ex_operand,
  input  logic [W-1:0] ex_amount_src,
  input  logic         ex_shift_left,
  input  logic         ex_arith,
  output logic [W-1:0] mem_result
);
  localparam int AMT_W = $clog2(W);
  localparam int LO_W  = AMT_W - 1;

  // ---------------- execute stage ----------------
  logic [AMT_W-1:0] ex_amt;
  logic             ex_right;
  logic             ex_fill;
  logic [W-1:0]     ex_mid;
  logic             ex_cap;

  assign ex_amt   = ex_amount_src[AMT_W-1:0];
  assign ex_right = ~ex_shift_left;
  assign ex_fill  = ex_arith & ex_right & ex_operand[W-1];
  assign ex_cap   = ex_run & ex_is_shift;

  bsh_ex_stage #(.W(W), .LO_W(LO_W)) u_ex (
    .operand (ex_operand),
    .amt_lo  (ex_amt[LO_W-1:0]),
    .right   (ex_right),
    .fill    (ex_fill),
    .mid     (ex_mid)
  );

  // ---------------- stage register ----------------
  logic [W-1:0] mid_q, mid_d;
  bsh_ctl_t     ctl_q, ctl_d;

  always_comb begin
    mid_d = mid_q;
    ctl_d = ctl_q;
    if (ex_cap) begin
      mid_d        = ex_mid;
      ctl_d.amt_hi = ex_amt[AMT_W-1];
      ctl_d.right  = ex_right;
      ctl_d.fill   = ex_fill;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q <= '0;
      ctl_q <= '0;
    end else begin
      mid_q <= mid_d;
      ctl_q <= ctl_d;
    end
  end

  // ---------------- memory stage ----------------
  logic [W-1:0] mem_shifted;

  bsh_layer #(.W(W), .SEL_W(1), .STEP(1 << LO_W)) u_mem_layer (
    .d    (mid_q),
    .sel  (ctl_q.amt_hi),
    .fill (ctl_q.fill),
    .q    (mem_shifted)
  );

  bsh_rev #(.W(W)) u_rev_out (
    .en (ctl_q.right),
    .d  (mem_shifted),
    .q  (mem_result)
  );

  // ---------------- assertions ----------------
  // R8
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_cap |=> $stable(mem_result));

  // R6
  zero_amt_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_cap && ex_amt == '0) |=> mem_result == $past(ex_operand));

  // R2
  logical_right_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_cap && !ex_shift_left && !ex_arith && ex_amt != '0) |=> !mem_result[W-1]);

  // R3
  arith_right_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_cap && !ex_shift_left && ex_arith) |=> mem_result[W-1] == $past(ex_operand[W-1]));

  // R1
  left_lsb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_cap && ex_shift_left && ex_amt != '0) |=> !mem_result[0]);

  // R9
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |-> mem_result == '0);
endmodule

// File: tb/sim_bsh_pipe.sv
module sim_bsh_pipe;
  logic clk, rst_n;

  logic        run8, sh8, l8, a8;
  logic [7:0]  op8, src8, res8;
  logic        run32, sh32, l32, a32;
  logic [31:0] op32, src32, res32;

  int n_cmp = 0;
  int n_bad = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  bsh_pipe #(.W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .ex_run(run8), .ex_is_shift(sh8),
    .ex_operand(op8), .ex_amount_src(src8), .ex_shift_left(l8),
    .ex_arith(a8), .mem_result(res8));

  bsh_pipe #(.W(32)) u1 (
    .clk(clk), .rst_n(rst_n), .ex_run(run32), .ex_is_shift(sh32),
    .ex_operand(op32), .ex_amount_src(src32), .ex_shift_left(l32),
    .ex_arith(a32), .mem_result(res32));

  function automatic logic [31:0] ref_shift(logic [31:0] op, int amt, bit left,
                                            bit arith, int w);
    logic [31:0] r = '0;
    for (int i = 0; i < w; i++) begin
      int s;
      if (left) begin
        s = i - amt;
        r[i] = (s >= 0) ? op[s] : 1'b0;
      end else begin
        s = i + amt;
        r[i] = (s < w) ? op[s] : (arith ? op[w-1] : 1'b0);
      end
    end
    return r;
  endfunction

  function automatic string tag_of(int amt, bit left, bit arith);
    if (amt == 0)           return "R6 R5 R7";
    if (left && arith)      return "R4 R5 R7";
    if (left)               return "R1 R5 R7";
    if (arith)              return "R3 R5 R7";
    return "R2 R5 R7";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL R7 watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] ops [16];
    logic [31:0] held;
    rst_n = 1'b0;
    run8 = 1'b1; sh8 = 1'b1; l8 = 1'b0; a8 = 1'b1; op8 = 8'hff; src8 = 8'h03;
    run32 = 1'b1; sh32 = 1'b1; l32 = 1'b1; a32 = 1'b0; op32 = '1; src32 = 32'h1;
    repeat (3) @(negedge clk);
    check("R9", {24'd0, res8}, 32'd0);
    check("R9", res32, 32'd0);
    run8 = 1'b0; run32 = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", {24'd0, res8}, 32'd0);
    check("R9", res32, 32'd0);

    // exhaustive sweep of the 8-bit instance
    run8 = 1'b1; sh8 = 1'b1;
    for (int op = 0; op < 256; op++) begin
      for (int amt = 0; amt < 8; amt++) begin
        for (int m = 0; m < 4; m++) begin
          logic [4:0] junk = 5'($urandom);
          op8 = 8'(op); src8 = {junk, 3'(amt)};
          l8 = m[0]; a8 = m[1];
          @(negedge clk);
          check(tag_of(amt, m[0], m[1]), {24'd0, res8},
                ref_shift(32'(op), amt, m[0], m[1], 8));
        end
      end
    end

    // 32-bit sweep over all distances and modes
    ops[0] = 32'h0000_0000; ops[1] = 32'hffff_ffff; ops[2] = 32'h8000_0000;
    ops[3] = 32'h0000_0001; ops[4] = 32'h7fff_ffff; ops[5] = 32'haaaa_5555;
    ops[6] = 32'h8000_0001; ops[7] = 32'h1234_abcd;
    for (int k = 8; k < 16; k++) ops[k] = $urandom;
    run32 = 1'b1; sh32 = 1'b1;
    for (int k = 0; k < 16; k++) begin
      for (int amt = 0; amt < 32; amt++) begin
        for (int m = 0; m < 4; m++) begin
          logic [26:0] junk = 27'($urandom);
          op32 = ops[k]; src32 = {junk, 5'(amt)};
          l32 = m[0]; a32 = m[1];
          @(negedge clk);
          check(tag_of(amt, m[0], m[1]), res32,
                ref_shift(ops[k], amt, m[0], m[1], 32));
        end
      end
    end

    // stall and non-shift hold
    op32 = 32'hc000_0f0f; src32 = 32'd20; l32 = 1'b0; a32 = 1'b1;
    @(negedge clk);
    held = ref_shift(32'hc000_0f0f, 20, 1'b0, 1'b1, 32);
    check("R7", res32, held);
    run32 = 1'b0; op32 = 32'h1111_2222; src32 = 32'd3; l32 = 1'b1; a32 = 1'b0;
    @(negedge clk);
    check("R8 stall", res32, held);
    @(negedge clk);
    check("R8 stall", res32, held);
    run32 = 1'b1; sh32 = 1'b0;
    @(negedge clk);
    check("R8 not-shift", res32, held);
    sh32 = 1'b1;
    @(negedge clk);
    check("R7", res32, 32'h8889_1110);

    summary();
    $finish;
  end
endmodule